// File: doc/BRIEF.md
# Physical Memory Protection Access Checker

This block decides whether one memory access may go ahead under a set of physical memory protection entries. Each request carries a byte address, a byte count, the read/write/execute rights it needs and the privilege mode of the requester. The entries arrive already decoded: each has an inclusive start and end byte address, a configuration byte and a lock flag. A count of active entries is also supplied. The registers that hold the entries, the decoding of entry addresses and the reporting of faults all belong to the surrounding logic.

The entries are searched in fixed priority order. Entry 0 has the highest priority. The lowest-numbered entry that touches the access settles the result alone. An access that lies only partly inside an entry is refused at once. When no entry touches the access, machine mode is allowed and every other mode is refused.

A small state machine produces a registered verdict one cycle after each request strobe. It has two states:
- `ST_IDLE`: no verdict is pending.
- `ST_RESP`: a verdict is presented.

It has three transitions:
- `ST_IDLE` to `ST_RESP` when a request is strobed.
- `ST_RESP` to `ST_RESP` on a back-to-back request.
- `ST_RESP` to `ST_IDLE` when no request follows.

Top module: `pmp_gate`

## Requirements
- R1: When `active_cnt` is zero, every request is allowed, whatever the privilege, address and rights.
- R2: Entries are examined from index 0 upward. The lowest-numbered entry that holds the first or the last byte of the access decides the result. Every higher entry is ignored.
- R3: The last byte of an access is `req_addr + req_size`, where `req_size` holds the byte count minus one. A last byte beyond the top of the address space lies outside every entry. If exactly one of the first and last bytes lies inside the deciding entry (start ≤ byte ≤ end), the access is denied.
- R4: The match mode is bits [4:3] of the entry's configuration byte. An entry whose match mode is 0 is off. An off entry never matches and never causes a split denial.
- R5: The entry's rights are configuration bit 0 = read, bit 1 = write and bit 2 = execute. For a non-machine requester, or for a locked entry, only those rights are granted. `req_perm` uses the same bit positions. The access is allowed only if every requested bit is granted.
- R6: A machine-mode request (`req_priv` = 3) that is fully inside an unlocked deciding entry is granted read, write and execute.
- R7: When no entry matches and at least one entry is active, a machine-mode request is allowed. Any other privilege value (0 user, 1 supervisor, 2 reserved) is denied.
- R8: `rsp_valid` rises on the clock edge after the edge that samples `req_valid`. It carries the verdict for that request. While `rsp_valid` is low, `rsp_allow` is low. After reset, `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | AW | First byte address |
| req_size | input | SW | Byte count minus one |
| req_perm | input | 3 | Requested rights: bit 0 read, bit 1 write, bit 2 execute |
| req_priv | input | 2 | Privilege: 3 machine, 1 supervisor, 0 user |
| ent_start | input | ENTRIES*AW | Inclusive start address per entry, entry i at [i*AW +: AW] |
| ent_end | input | ENTRIES*AW | Inclusive end address per entry |
| ent_cfg | input | ENTRIES*8 | Configuration byte per entry |
| ent_lock | input | ENTRIES | Lock flag per entry |
| active_cnt | input | $clog2(ENTRIES+1) | Number of active entries |
| rsp_valid | output | 1 | Verdict present |
| rsp_allow | output | 1 | 1 = access allowed |

## Verification
The hardest case to reach from the ports is an access that several entries cover at once, where the answer depends on which entry wins. One such case is an access that straddles the end of entry 0 while lying wholly inside a wider entry 1; the right answer is a denial. The other is an access that fits entry 0 but is refused by it, even though entry 1 would grant it. The stimulus sets up two overlapping entries with different rights so that both cases come up.

An access whose last byte wraps past the top of the address space needs an entry that ends at the very last address. The bench rewrites an off entry into such an entry for a directed check.

// File: rtl/pmp_gate_pkg.sv
package pmp_gate_pkg;
    typedef enum logic [1:0] {
        HIT_NONE  = 2'd0,
        HIT_FULL  = 2'd1,
        HIT_SPLIT = 2'd2
    } hit_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } state_e;

    localparam logic [1:0] PRIV_MACHINE = 2'd3;
    localparam int         MODE_LSB     = 3;
endpackage

// File: rtl/pmp_gate_match.sv
module pmp_gate_match
    import pmp_gate_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] first_b,
    input  logic [AW:0]   last_b,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic [1:0]    mode,
    output hit_e          hit
);
    logic first_in;
    logic last_in;

    always_comb begin
        first_in = (first_b >= lo) && (first_b <= hi);
        last_in  = (last_b >= {1'b0, lo}) && (last_b <= {1'b0, hi});
        if (mode == 2'd0) begin
            hit = HIT_NONE;
        end else if (first_in && last_in) begin
            hit = HIT_FULL;
        end else if (first_in || last_in) begin
            hit = HIT_SPLIT;
        end else begin
            hit = HIT_NONE;
        end
    end
endmodule

// File: rtl/pmp_gate_select.sv
module pmp_gate_select
    import pmp_gate_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  hit_e                 hits [ENTRIES],
    input  logic [ENTRIES*8-1:0] cfg,
    input  logic [ENTRIES-1:0]   lock,
    input  logic                 machine,
    output logic                 found,
    output logic                 split,
    output logic [2:0]           grant
);
    always_comb begin
        found = 1'b0;
        split = 1'b0;
        grant = 3'b000;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hits[i] != HIT_NONE) begin
                found = 1'b1;
                split = (hits[i] == HIT_SPLIT);
                grant = (machine && !lock[i]) ? 3'b111 : cfg[i*8 +: 3];
            end
        end
    end
endmodule

// File: rtl/pmp_gate.sv
module pmp_gate
    import pmp_gate_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int AW      = 32,
    parameter int SW      = 4,
    localparam int CW     = $clog2(ENTRIES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [AW-1:0]         req_addr,
    input  logic [SW-1:0]         req_size,
    input  logic [2:0]            req_perm,
    input  logic [1:0]            req_priv,
    input  logic [ENTRIES*AW-1:0] ent_start,
    input  logic [ENTRIES*AW-1:0] ent_end,
    input  logic [ENTRIES*8-1:0]  ent_cfg,
    input  logic [ENTRIES-1:0]    ent_lock,
    input  logic [CW-1:0]         active_cnt,
    output logic                  rsp_valid,
    output logic                  rsp_allow
);
    state_e     state_q, state_d;
    logic [AW:0] last_b;
    hit_e       hits [ENTRIES];
    logic       found, split, machine, allow_d;
    logic [2:0] grant;

    assign machine = (req_priv == PRIV_MACHINE);
    assign last_b  = {1'b0, req_addr} + {{(AW + 1 - SW){1'b0}}, req_size};

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        pmp_gate_match #(.AW(AW)) u_match (
            .first_b (req_addr),
            .last_b  (last_b),
            .lo      (ent_start[g*AW +: AW]),
            .hi      (ent_end[g*AW +: AW]),
            .mode    (ent_cfg[g*8 + MODE_LSB +: 2]),
            .hit     (hits[g])
        );
    end

    pmp_gate_select #(.ENTRIES(ENTRIES)) u_select (
        .hits    (hits),
        .cfg     (ent_cfg),
        .lock    (ent_lock),
        .machine (machine),
        .found   (found),
        .split   (split),
        .grant   (grant)
    );

    always_comb begin
        if (active_cnt == '0) begin
            allow_d = 1'b1;
        end else if (!found) begin
            allow_d = machine;
        end else if (split) begin
            allow_d = 1'b0;
        end else begin
            allow_d = ((req_perm & ~grant) == 3'b000);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)  state_d = ST_RESP;
            ST_RESP: if (!req_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rsp_allow <= 1'b0;
        else if (req_valid) rsp_allow <= allow_d;
        else                rsp_allow <= 1'b0;
    end

    assign rsp_valid = (state_q == ST_RESP);
endmodule

// File: rtl/pmp_gate_chk.sv
module pmp_gate_chk #(
    parameter int ENTRIES = 4,
    parameter int AW      = 32,
    parameter int SW      = 4,
    localparam int CW     = $clog2(ENTRIES + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [SW-1:0]        req_size,
    input logic [1:0]           req_priv,
    input logic [ENTRIES*8-1:0] ent_cfg,
    input logic [ENTRIES-1:0]   ent_lock,
    input logic [CW-1:0]        active_cnt,
    input logic                 rsp_valid,
    input logic                 rsp_allow
);
    logic any_on;

    always_comb begin
        any_on = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (ent_cfg[i*8 + 3 +: 2] != 2'd0) any_on = 1'b1;
        end
    end

    assert_empty_allows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && active_cnt == '0) |=> (rsp_valid && rsp_allow));

    assert_off_never_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && active_cnt != '0 && !any_on && req_priv != 2'd3) |=> !rsp_allow);

    assert_machine_unlocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv == 2'd3 && ent_lock == '0 && req_size == '0) |=> rsp_allow);

    assert_resp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_resp_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_allow_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_allow);
endmodule

bind pmp_gate pmp_gate_chk #(.ENTRIES(ENTRIES), .AW(AW), .SW(SW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_size   (req_size),
    .req_priv   (req_priv),
    .ent_cfg    (ent_cfg),
    .ent_lock   (ent_lock),
    .active_cnt (active_cnt),
    .rsp_valid  (rsp_valid),
    .rsp_allow  (rsp_allow)
);

// File: tb/test_pmp_gate.sv
module test_pmp_gate;
    localparam int ENTRIES = 4;
    localparam int AW      = 32;
    localparam int SW      = 4;
    localparam int CW      = $clog2(ENTRIES + 1);
    localparam time CLK_PERIOD = 10ns;
    localparam int NVEC    = 12;

    // vector: addr[41:10] size[9:6] perm[5:3] priv[2:1] expect[0]
    localparam logic [41:0] VECS [NVEC] = '{
        {32'h0000_1010, 4'd3, 3'b001, 2'd0, 1'b1},  // R5 read inside entry 0
        {32'h0000_1010, 4'd3, 3'b010, 2'd0, 1'b0},  // R2 entry 0 refuses write, entry 1 ignored
        {32'h0000_1200, 4'd3, 3'b010, 2'd1, 1'b1},  // R5 entry 1 grants write
        {32'h0000_10FE, 4'd3, 3'b001, 2'd0, 1'b0},  // R3 straddles end of entry 0
        {32'h0000_1010, 4'd3, 3'b010, 2'd3, 1'b1},  // R6 machine unlocked
        {32'h0000_3010, 4'd3, 3'b001, 2'd3, 1'b0},  // R5 locked entry binds machine
        {32'h0000_3010, 4'd3, 3'b100, 2'd3, 1'b1},  // R5 locked execute granted
        {32'h0000_4010, 4'd0, 3'b001, 2'd0, 1'b0},  // R4 off entry, user denied
        {32'h0000_4010, 4'd0, 3'b001, 2'd3, 1'b1},  // R7 no match machine allowed
        {32'h0000_5000, 4'd7, 3'b100, 2'd1, 1'b0},  // R7 no match supervisor denied
        {32'h0000_1FFE, 4'd3, 3'b001, 2'd1, 1'b0},  // R3 straddles end of entry 1
        {32'h0000_1000, 4'd0, 3'b111, 2'd0, 1'b0}   // R5 all rights, only read held
    };

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  req_valid = 1'b0;
    logic [AW-1:0]         req_addr = '0;
    logic [SW-1:0]         req_size = '0;
    logic [2:0]            req_perm = '0;
    logic [1:0]            req_priv = '0;
    logic [ENTRIES*AW-1:0] ent_start = '0;
    logic [ENTRIES*AW-1:0] ent_end = '0;
    logic [ENTRIES*8-1:0]  ent_cfg = '0;
    logic [ENTRIES-1:0]    ent_lock = '0;
    logic [CW-1:0]         active_cnt = '0;
    logic                  rsp_valid, rsp_allow;
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pmp_gate #(.ENTRIES(ENTRIES), .AW(AW), .SW(SW)) i_pmp_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_perm(req_perm), .req_priv(req_priv),
        .ent_start(ent_start), .ent_end(ent_end), .ent_cfg(ent_cfg),
        .ent_lock(ent_lock), .active_cnt(active_cnt),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow)
    );

    task automatic check(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic access(input string req, input logic [AW-1:0] a, input logic [SW-1:0] s,
                          input logic [2:0] p, input logic [1:0] v, input logic exp);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = s; req_perm = p; req_priv = v;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, rsp_valid, 1'b1);
        check(req, rsp_allow, exp);
    endtask

    task automatic set_entry(input int i, input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                             input logic [7:0] c, input logic lk);
        ent_start[i*AW +: AW] = lo;
        ent_end[i*AW +: AW]   = hi;
        ent_cfg[i*8 +: 8]     = c;
        ent_lock[i]           = lk;
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        set_entry(0, 32'h0000_1000, 32'h0000_10FF, 8'h09, 1'b0);
        set_entry(1, 32'h0000_1000, 32'h0000_1FFF, 8'h0B, 1'b0);
        set_entry(2, 32'h0000_3000, 32'h0000_30FF, 8'h0C, 1'b1);
        set_entry(3, 32'h0000_4000, 32'h0000_4FFF, 8'h07, 1'b0);
        repeat (3) @(negedge clk);
        check("R8 reset valid", rsp_valid, 1'b0);
        check("R8 reset allow", rsp_allow, 1'b0);
        rst_n = 1'b1;

        // R1: no active entries, user request anywhere is allowed
        active_cnt = '0;
        access("R1 empty user", 32'h0000_1010, 4'd3, 3'b111, 2'd0, 1'b1);
        access("R1 empty user off-range", 32'h0000_5000, 4'd0, 3'b010, 2'd0, 1'b1);

        active_cnt = CW'(3);
        for (int k = 0; k < NVEC; k++) begin
            access($sformatf("vector %0d", k), VECS[k][41:10], VECS[k][9:6],
                   VECS[k][5:3], VECS[k][2:1], VECS[k][0]);
        end

        // R8: idle after strobe drops
        @(negedge clk);
        check("R8 idle valid", rsp_valid, 1'b0);
        check("R8 idle allow", rsp_allow, 1'b0);

        // R8: back-to-back requests each get their own verdict
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_1010; req_size = 4'd0; req_perm = 3'b001; req_priv = 2'd0;
        @(negedge clk);
        check("R8 b2b first", rsp_allow, 1'b1);
        req_perm = 3'b010;
        @(negedge clk);
        check("R8 b2b second valid", rsp_valid, 1'b1);
        check("R8 b2b second", rsp_allow, 1'b0);
        req_valid = 1'b0;

        // R3: last byte wraps past the top of the address space
        set_entry(3, 32'hFFFF_0000, 32'hFFFF_FFFF, 8'h0F, 1'b0);
        access("R3 top exact", 32'hFFFF_FFFE, 4'd1, 3'b001, 2'd0, 1'b1);
        access("R3 top wrap", 32'hFFFF_FFFE, 4'd3, 3'b001, 2'd0, 1'b0);

        // R2: straddle on entry 0 denies machine too, even though entry 1 holds it
        access("R2 straddle machine", 32'h0000_10FE, 4'd3, 3'b001, 2'd3, 1'b0);

        // R7: reserved privilege value is not machine
        access("R7 reserved priv", 32'h0000_6000, 4'd0, 3'b001, 2'd2, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule